// File: doc/BRIEF.md
# Interval Timer With Register Bus

A down-counting interval timer that sits on a simple word-addressed register bus. Software programs a 32-bit period through two 16-bit period registers, sets the mode and interrupt enable through a control register, and starts or stops the count with self-clearing command bits. Each time the count passes through zero, the timer sets a timeout flag, reloads the period, and either keeps running (continuous mode) or halts (one-shot mode). The interrupt line is the timeout flag gated by the interrupt enable. Software acknowledges an interrupt by writing any value to the status register.

Two build-time options change how period writes behave. With a writable period, the halves are stored. With a fixed period, the written data is discarded and the counter reloads the build-time default. With start/stop control present, a period write also halts the counter. Without start/stop control, the counter runs freely from reset, and the start, stop and continuous bits have no effect on it.

Top module: `interval_timer`

## Requirements
- R1: After reset the status, control and high-period words read 0, the low-period word reads the low half of the default period, and `irq` is 0. Without start/stop control, status bit 1 (running) reads 1 straight after reset.
- R2: Word 2 holds period bits 15:0 and word 3 holds period bits 31:16. When the period is writable, both words read back what was written to them.
- R3: A write to word 2 or word 3 reloads the counter with the new period. With start/stop control present, the same write halts the counter.
- R4: When the period is fixed, a period write leaves both period words unchanged. It reloads the counter with the default period, so the next timeout comes default+1 cycles after that write.
- R5: Without start/stop control, period writes and stop commands leave the counter running.
- R6: Once running, the counter decrements on every clock. The cycle after it holds zero, the timeout flag (status bit 0) sets, so a period P gives P+1 cycles from start to flag.
- R7: At a timeout the counter reloads the period. With control bit 1 (continuous) set it keeps running and times out every P+1 cycles; with the bit clear it halts (status bit 1 goes to 0).
- R8: A write of any data to word 0 clears the timeout flag and `irq`.
- R9: `irq` is high exactly when the timeout flag is set and control bit 0 (interrupt enable) is set.
- R10: Control bit 2 (start) resumes a halted counter from its held count without reloading it. On a running counter it changes nothing.
- R11: Control bit 3 (stop) halts the counter and wins over start in the same write. The counter keeps its count while halted.
- R12: Control reads return bits 0 and 1 as written; start, stop and all other bits read 0. When no read strobe is active, `bus_rdata` is 0.
- R13: If a timeout and a status write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 status, 1 control, 2 period low, 3 period high |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when `bus_rd` is low |
| irq | output | 1 | Timeout interrupt, level |

## Verification
Several properties are checked on every cycle. A period write must reload the counter with the period that write produced, and must halt the counter when start/stop control exists. A stop command must leave the counter halted. A running, non-zero count must drop by exactly one, and a zero count must raise the flag on the next edge. A status write outside a timeout must leave the flag clear. Other behaviours depend on sequences of bus operations, and only the bench scenarios show them. These are the exact cycle of each timeout, the difference between one-shot and continuous mode, that start on a running counter does not reload it, that a halted counter resumes from its held count, the fixed-period reload, and the free-running build without start/stop control.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        WORD_STATUS = 2'd0,
        WORD_CTRL   = 2'd1,
        WORD_PER_LO = 2'd2,
        WORD_PER_HI = 2'd3
    } word_addr_e;

    localparam int CTL_IRQ_EN = 0;
    localparam int CTL_CONT   = 1;
    localparam int CTL_START  = 2;
    localparam int CTL_STOP   = 3;

    localparam int STS_FLAG   = 0;
    localparam int STS_RUN    = 1;

    typedef struct packed {
        logic cont;
        logic irq_en;
    } ctrl_t;

endpackage

// File: rtl/timer_regfile.sv
module timer_regfile
    import timer_pkg::*;
#(
    parameter int unsigned REG_W           = 16,
    parameter int unsigned DEFAULT_PERIOD  = 49999,
    parameter bit          PERIOD_WRITABLE = 1'b1,
    localparam int unsigned CNT_W          = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  word_addr_e       addr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] period_next,
    output logic             cmd_start,
    output logic             cmd_stop,
    output logic             period_wr,
    output logic             status_wr
);

    localparam logic [CNT_W-1:0] DEF_CNT = CNT_W'(DEFAULT_PERIOD);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
    } rf_t;

    rf_t  rf_d, rf_q;
    logic ctrl_wr;

    assign status_wr = wr_en && (addr == WORD_STATUS);
    assign ctrl_wr   = wr_en && (addr == WORD_CTRL);
    assign period_wr = wr_en && ((addr == WORD_PER_LO) || (addr == WORD_PER_HI));
    assign cmd_start = ctrl_wr && wdata[CTL_START];
    assign cmd_stop  = ctrl_wr && wdata[CTL_STOP];

    generate
        if (PERIOD_WRITABLE) begin : g_writable
            always_comb begin
                period_next = rf_q.period;
                if (wr_en && addr == WORD_PER_LO) begin
                    period_next[REG_W-1:0] = wdata;
                end
                if (wr_en && addr == WORD_PER_HI) begin
                    period_next[CNT_W-1:REG_W] = wdata;
                end
            end
        end else begin : g_fixed
            assign period_next = DEF_CNT;
        end
    endgenerate

    always_comb begin
        rf_d        = rf_q;
        rf_d.period = period_next;
        if (ctrl_wr) begin
            rf_d.ctrl.irq_en = wdata[CTL_IRQ_EN];
            rf_d.ctrl.cont   = wdata[CTL_CONT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.ctrl   <= '0;
            rf_q.period <= DEF_CNT;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign ctrl_q   = rf_q.ctrl;
    assign period_q = rf_q.period;

    assert_ctrl_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/timer_core.sv
module timer_core #(
    parameter int unsigned CNT_W          = 32,
    parameter int unsigned DEFAULT_PERIOD = 49999,
    parameter bit          HAS_RUN_CTRL   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cont,
    input  logic             period_wr,
    input  logic             status_wr,
    input  logic [CNT_W-1:0] reload_val,
    output logic             running,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] DEF_CNT = CNT_W'(DEFAULT_PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
        logic             flag;
    } core_t;

    core_t s_d, s_q;
    logic  hit_zero;

    assign hit_zero = s_q.running && (s_q.count == '0) && !period_wr;

    always_comb begin
        s_d = s_q;
        if (status_wr) begin
            s_d.flag = 1'b0;
        end
        if (period_wr) begin
            s_d.count = reload_val;
            if (HAS_RUN_CTRL) begin
                s_d.running = 1'b0;
            end
        end else if (s_q.running) begin
            if (hit_zero) begin
                s_d.count = reload_val;
                s_d.flag  = 1'b1;
                if (HAS_RUN_CTRL && !cont) begin
                    s_d.running = 1'b0;
                end
            end else begin
                s_d.count = s_q.count - 1'b1;
            end
        end
        if (HAS_RUN_CTRL) begin
            if (cmd_stop) begin
                s_d.running = 1'b0;
            end else if (cmd_start) begin
                s_d.running = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count   <= DEF_CNT;
            s_q.running <= !HAS_RUN_CTRL;
            s_q.flag    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign running = s_q.running;
    assign timeout = s_q.flag;

    assert_period_wr_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> s_q.count == $past(reload_val));

    assert_period_wr_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_RUN_CTRL && period_wr) |=> !s_q.running);

    assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.running && s_q.count != '0 && !period_wr) |=> s_q.count == $past(s_q.count) - 1'b1);

    assert_flag_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_zero |=> s_q.flag);

    assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && !hit_zero) |=> !s_q.flag);

    assert_stop_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_RUN_CTRL && cmd_stop) |=> !s_q.running);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int unsigned REG_W           = 16,
    parameter int unsigned DEFAULT_PERIOD  = 49999,
    parameter bit          PERIOD_WRITABLE = 1'b1,
    parameter bit          HAS_RUN_CTRL    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq
);

    localparam int unsigned CNT_W = 2 * REG_W;

    word_addr_e       addr;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] period_next;
    logic             cmd_start, cmd_stop, period_wr, status_wr;
    logic             running, timeout;
    logic [REG_W-1:0] rd_mux;

    assign addr = word_addr_e'(bus_addr);

    timer_regfile #(
        .REG_W          (REG_W),
        .DEFAULT_PERIOD (DEFAULT_PERIOD),
        .PERIOD_WRITABLE(PERIOD_WRITABLE)
    ) i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (addr),
        .wdata      (bus_wdata),
        .ctrl_q     (ctrl_q),
        .period_q   (period_q),
        .period_next(period_next),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .period_wr  (period_wr),
        .status_wr  (status_wr)
    );

    timer_core #(
        .CNT_W         (CNT_W),
        .DEFAULT_PERIOD(DEFAULT_PERIOD),
        .HAS_RUN_CTRL  (HAS_RUN_CTRL)
    ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cont      (ctrl_q.cont),
        .period_wr (period_wr),
        .status_wr (status_wr),
        .reload_val(period_next),
        .running   (running),
        .timeout   (timeout)
    );

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            WORD_STATUS: begin
                rd_mux[STS_FLAG] = timeout;
                rd_mux[STS_RUN]  = running;
            end
            WORD_CTRL: begin
                rd_mux[CTL_IRQ_EN] = ctrl_q.irq_en;
                rd_mux[CTL_CONT]   = ctrl_q.cont;
            end
            WORD_PER_LO: rd_mux = period_q[REG_W-1:0];
            WORD_PER_HI: rd_mux = period_q[CNT_W-1:REG_W];
            default:     rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
    assign irq       = timeout && ctrl_q.irq_en;

    assert_idle_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (timeout && ($rose(timeout) || $rose(ctrl_q.irq_en))));

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;

    localparam logic [1:0] K_W = 2'd0;
    localparam logic [1:0] K_R = 2'd1;
    localparam logic [1:0] K_N = 2'd2;
    localparam logic [1:0] K_I = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  addr;
        logic [15:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int N_VEC = 69;

    localparam vec_t VEC [N_VEC] = '{
        // R1 reset values
        '{K_R, 2'd0, 16'h0000, 8'd1}, '{K_R, 2'd1, 16'h0000, 8'd1},
        '{K_R, 2'd2, 16'h0008, 8'd1}, '{K_R, 2'd3, 16'h0000, 8'd1},
        '{K_I, 2'd0, 16'h0000, 8'd1},
        // R2 split period readback
        '{K_W, 2'd3, 16'h0001, 8'd2}, '{K_R, 2'd3, 16'h0001, 8'd2},
        '{K_W, 2'd2, 16'h0005, 8'd2}, '{K_R, 2'd2, 16'h0005, 8'd2},
        '{K_R, 2'd3, 16'h0001, 8'd2}, '{K_W, 2'd3, 16'h0000, 8'd2},
        '{K_R, 2'd3, 16'h0000, 8'd2},
        // R6 one-shot start, flag P+1 cycles later; R7 halts; R9 irq
        '{K_W, 2'd1, 16'h0005, 8'd6}, '{K_R, 2'd0, 16'h0002, 8'd6},
        '{K_N, 2'd0, 16'h0005, 8'd6}, '{K_R, 2'd0, 16'h0002, 8'd6},
        '{K_N, 2'd0, 16'h0001, 8'd6}, '{K_R, 2'd0, 16'h0001, 8'd7},
        '{K_I, 2'd0, 16'h0001, 8'd9},
        // R8 clear with arbitrary data
        '{K_W, 2'd0, 16'hABCD, 8'd8}, '{K_R, 2'd0, 16'h0000, 8'd8},
        '{K_I, 2'd0, 16'h0000, 8'd8},
        // R7 continuous mode repeats
        '{K_W, 2'd1, 16'h0007, 8'd7}, '{K_N, 2'd0, 16'h0006, 8'd7},
        '{K_R, 2'd0, 16'h0003, 8'd7}, '{K_W, 2'd0, 16'h0000, 8'd8},
        '{K_R, 2'd0, 16'h0002, 8'd8}, '{K_N, 2'd0, 16'h0005, 8'd7},
        '{K_R, 2'd0, 16'h0003, 8'd7},
        // R10 start while running does not reload
        '{K_W, 2'd1, 16'h0007, 8'd10}, '{K_W, 2'd0, 16'h0000, 8'd10},
        '{K_N, 2'd0, 16'h0003, 8'd10}, '{K_R, 2'd0, 16'h0002, 8'd10},
        '{K_N, 2'd0, 16'h0001, 8'd10}, '{K_R, 2'd0, 16'h0003, 8'd10},
        // R11 stop wins over start, start/stop read zero, count held
        '{K_W, 2'd1, 16'h000F, 8'd11}, '{K_R, 2'd0, 16'h0001, 8'd11},
        '{K_R, 2'd1, 16'h0003, 8'd11}, '{K_W, 2'd0, 16'h0000, 8'd11},
        '{K_N, 2'd0, 16'h0004, 8'd11}, '{K_R, 2'd0, 16'h0000, 8'd11},
        // R10 resume from held count
        '{K_W, 2'd1, 16'h0007, 8'd10}, '{K_N, 2'd0, 16'h0004, 8'd10},
        '{K_R, 2'd0, 16'h0002, 8'd10}, '{K_N, 2'd0, 16'h0001, 8'd10},
        '{K_R, 2'd0, 16'h0003, 8'd10},
        // R3 period write halts and reloads
        '{K_W, 2'd2, 16'h0003, 8'd3}, '{K_R, 2'd0, 16'h0001, 8'd3},
        '{K_W, 2'd0, 16'h0000, 8'd3}, '{K_N, 2'd0, 16'h0006, 8'd3},
        '{K_R, 2'd0, 16'h0000, 8'd3}, '{K_W, 2'd1, 16'h0007, 8'd3},
        '{K_N, 2'd0, 16'h0003, 8'd3}, '{K_R, 2'd0, 16'h0002, 8'd3},
        '{K_N, 2'd0, 16'h0001, 8'd3}, '{K_R, 2'd0, 16'h0003, 8'd3},
        // R9 enable gates irq
        '{K_W, 2'd1, 16'h0002, 8'd9}, '{K_I, 2'd0, 16'h0000, 8'd9},
        '{K_R, 2'd0, 16'h0003, 8'd9}, '{K_W, 2'd1, 16'h0003, 8'd9},
        '{K_I, 2'd0, 16'h0001, 8'd9},
        // R11 halt at zero, then R13 timeout against status write
        '{K_W, 2'd1, 16'h0008, 8'd11}, '{K_W, 2'd0, 16'h0000, 8'd11},
        '{K_R, 2'd0, 16'h0000, 8'd11}, '{K_W, 2'd1, 16'h0007, 8'd13},
        '{K_W, 2'd0, 16'h0000, 8'd13}, '{K_R, 2'd0, 16'h0003, 8'd13},
        // R12 control readback masks command and unused bits
        '{K_W, 2'd1, 16'hFFFF, 8'd12}, '{K_R, 2'd1, 16'h0003, 8'd12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
    logic [15:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    interval_timer #(
        .REG_W(16), .DEFAULT_PERIOD(8), .PERIOD_WRITABLE(1'b1), .HAS_RUN_CTRL(1'b1)
    ) i_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(a_wr), .bus_rd(a_rd),
        .bus_wdata(wdata), .bus_rdata(a_rdata), .irq(a_irq)
    );

    interval_timer #(
        .REG_W(16), .DEFAULT_PERIOD(6), .PERIOD_WRITABLE(1'b0), .HAS_RUN_CTRL(1'b0)
    ) i_interval_timer_fixed (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(b_wr), .bus_rd(b_rd),
        .bus_wdata(wdata), .bus_rdata(b_rdata), .irq(b_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input bit fixed, input logic [1:0] a, input logic [15:0] d);
        addr  = a;
        wdata = d;
        if (fixed) b_wr = 1'b1; else a_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        a_wr = 1'b0;
        b_wr = 1'b0;
    endtask

    task automatic bus_read(input bit fixed, input logic [1:0] a, input logic [15:0] exp,
                            input string tag);
        addr = a;
        if (fixed) b_rd = 1'b1; else a_rd = 1'b1;
        #2;
        check(tag, fixed ? b_rdata : a_rdata, exp);
        a_rd = 1'b0;
        b_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R5: the free-running build shows running right after reset
        bus_read(1'b1, 2'd0, 16'h0002, "R1");
        // R4: fixed build reads the default and ignores period writes
        bus_read(1'b1, 2'd2, 16'h0006, "R4");
        bus_write(1'b1, 2'd2, 16'h1234);
        bus_read(1'b1, 2'd2, 16'h0006, "R4");
        bus_read(1'b1, 2'd3, 16'h0000, "R4");
        bus_write(1'b1, 2'd0, 16'h0000);
        repeat (5) @(negedge clk);
        bus_read(1'b1, 2'd0, 16'h0002, "R5");
        @(negedge clk);
        bus_read(1'b1, 2'd0, 16'h0003, "R4");
        // R5: stop has no effect without start/stop control
        bus_write(1'b1, 2'd1, 16'h0008);
        bus_read(1'b1, 2'd0, 16'h0003, "R5");

        for (int i = 0; i < N_VEC; i++) begin
            case (VEC[i].kind)
                K_W: bus_write(1'b0, VEC[i].addr, VEC[i].data);
                K_R: bus_read(1'b0, VEC[i].addr, VEC[i].data,
                              $sformatf("R%0d row %0d", VEC[i].req, i));
                K_N: repeat (int'(VEC[i].data)) @(negedge clk);
                default: begin
                    #2;
                    check($sformatf("R%0d row %0d irq", VEC[i].req, i),
                          {15'd0, a_irq}, VEC[i].data);
                end
            endcase
        end

        // R12: idle bus reads zero
        #2;
        check("R12 idle", a_rdata, 16'h0000);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule